// File: doc/BRIEF.md
# Per-Lane Delay Window Scanner

This block finds the passing window of a delay tap for up to nine byte lanes at once. It steps a shared tap value across its whole range and gives each lane a programmed delay derived from that tap. At every tap it asks an external read-compare engine for a verdict, and the engine answers with one fail bit per lane. Each lane runs its own small tracker. The tracker looks for a fail-to-pass edge and then a pass-to-fail edge. It rejects windows that are too narrow, which filters out false passes, and locks the lane once it has a credible window.

A full run is made of eight sweeps, one per victim-bit pattern. The victim index is driven out so that the compare engine can pick its pattern. The edges found in each sweep are merged into a running intersection, so the reported window is the one that passes for every victim bit. Receive runs sweep the tap upward and drive it directly. Transmit runs sweep the tap downward and add a per-lane write-levelling offset to form the programmed delay.

A pulse on `start` begins a run and `done` marks its end. Reported limits are tap values, not programmed delays.

Top module: `dly_window_scan`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `cmp_req` are low, and every lane reports a low limit of 0 and a high limit of 31.
- R2: When `start` is seen while idle, `dir_tx` (1 = transmit) and `lane_en` are latched and `err` is cleared. `busy` then stays high until the cycle in which `done` pulses high for exactly one cycle.
- R3: In a receive run the tap starts at 0 and rises by one per step, and each lane's delay equals the tap. In a transmit run the tap starts at 31 and falls by one per step, and lane i's delay equals the tap plus `wl_off[5*i+4:5*i]`. The delay does not change while a compare is outstanding.
- R4: Each tap gets exactly three compares. Each compare is a one-cycle `cmp_req` pulse answered by one `cmp_ack` cycle that carries `cmp_fail`. A lane is treated as failing at that tap if any of the three answers had its bit set.
- R5: In a receive sweep, the first passing tap becomes the low limit, and on the next failing tap T the high limit becomes T-1. In a transmit sweep, the first passing tap becomes the high limit, and on the next failing tap T the low limit becomes T+1.
- R6: A window whose high minus low is below 3 (MIN_WIN) is rejected. The lane goes back to seeking a pass and keeps sweeping. A width of exactly 3 is accepted and locks the lane.
- R7: A lane still inside its window when the sweep reaches its last tap takes that end as its open edge. For receive the high limit is 31. For transmit the low limit is 0.
- R8: If the sweep reaches its last tap with an enabled lane that has never found a window, `err` is set, the run is abandoned without further sweeps, and `done` pulses.
- R9: A sweep stops at the first tap after which every enabled lane is locked. No further compares are issued for that sweep.
- R10: `victim` counts from 0 to 7, one sweep each. The reported low limit is the largest low over all sweeps, and the reported high limit is the smallest high over all sweeps.
- R11: Lanes not set in `lane_en` take no part. Their fail bits never raise `err` or extend a sweep, and they report 0 and 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (accepted while idle) |
| dir_tx | input | 1 | 1 = transmit sweep, 0 = receive sweep |
| lane_en | input | 9 | Active lanes |
| wl_off | input | 45 | Per-lane write-levelling offset, 5 bits per lane |
| cmp_ack | input | 1 | Compare answer valid |
| cmp_fail | input | 9 | Per-lane fail bits, valid with cmp_ack |
| cmp_req | output | 1 | One-cycle compare request |
| victim | output | 3 | Victim-bit index of the current sweep |
| lane_dly | output | 54 | Programmed delay per lane, 6 bits per lane |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | A lane found no window |
| low_lim | output | 45 | Low window limit per lane, 5 bits per lane |
| high_lim | output | 45 | High window limit per lane, 5 bits per lane |

## Verification
The hardest situations to reach from the ports are a false pass followed by a real window inside one sweep, and a failure that shows up in only one of the three compares at a single tap. The bench models the compare engine with a per-lane, per-victim pass window. It adds a separate short pass island ahead of the real window, and it can force one failure on a chosen lane, tap, victim and attempt number. This drives the tracker through its re-arm path and the retry merge at exact taps with known expected limits.

// File: rtl/dws_pkg.sv
// Shared types for the delay window scanner.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package dws_pkg;
    // Per-lane tracker: seeking a pass, inside a window, or locked.
    typedef enum logic [1:0] {LN_SEEK, LN_OPEN, LN_LOCK} lane_st_t;
    // Sweep sequencer states.
    typedef enum logic [2:0] {
        SW_IDLE, SW_ARM, SW_REQ, SW_WAIT, SW_STEP, SW_CHECK, SW_MERGE, SW_DONE
    } sw_st_t;
endpackage

// File: rtl/dws_lane.sv
// One lane's window tracker plus its cross-sweep intersection.
// Assumes: step is issued once per tap with the merged fail bit; arm precedes
// each sweep; merge follows a sweep that ended without error.
module dws_lane
    import dws_pkg::*;
#(
    parameter int TAP_W   = 5,
    parameter int MIN_WIN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             is_tx,
    input  logic [TAP_W-1:0] tap,
    input  logic             acc_init,
    input  logic             arm,
    input  logic             step,
    input  logic             fail,
    input  logic             merge,
    output logic             locked,
    output logic             seeking,
    output logic [TAP_W-1:0] acc_lo,
    output logic [TAP_W-1:0] acc_hi
);
    localparam logic [TAP_W-1:0] TAP_TOP = '1;

    lane_st_t         st;
    logic [TAP_W-1:0] lo, hi, new_lo, new_hi, eff_lo, eff_hi;
    logic [TAP_W:0]   span;
    logic             wide_ok;

    // Closing edge and width test for a pass-to-fail transition.
    always_comb begin
        new_lo  = is_tx ? tap + 1'b1 : lo;
        new_hi  = is_tx ? hi : tap - 1'b1;
        span    = {1'b0, new_hi} - {1'b0, new_lo};
        wide_ok = (new_hi >= new_lo) && (span >= (TAP_W+1)'(MIN_WIN));
    end

    // Edges seen at sweep end; an open window takes the sweep end as its edge.
    always_comb begin
        eff_lo = (st == LN_OPEN && is_tx)  ? '0      : lo;
        eff_hi = (st == LN_OPEN && !is_tx) ? TAP_TOP : hi;
    end

    // Tracker state and edges of the current sweep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= LN_SEEK;
            lo <= '0;
            hi <= TAP_TOP;
        end else if (arm) begin
            st <= en ? LN_SEEK : LN_LOCK;
        end else if (step && en) begin
            case (st)
                LN_SEEK: if (!fail) begin
                    st <= LN_OPEN;
                    if (is_tx) hi <= tap;
                    else       lo <= tap;
                end
                LN_OPEN: if (fail) begin
                    lo <= new_lo;
                    hi <= new_hi;
                    st <= wide_ok ? LN_LOCK : LN_SEEK;
                end
                default: ;
            endcase
        end
    end

    // Running intersection over victim sweeps.
    always_ff @(posedge clk) begin
        if (!rst_n || acc_init) begin
            acc_lo <= '0;
            acc_hi <= TAP_TOP;
        end else if (merge && en) begin
            if (eff_lo > acc_lo) acc_lo <= eff_lo;
            if (eff_hi < acc_hi) acc_hi <= eff_hi;
        end
    end

    assign locked  = (st == LN_LOCK);
    assign seeking = en && (st == LN_SEEK);
endmodule

// File: rtl/dws_ctrl.sv
// Sweep sequencer: runs victim sweeps, issues repeated compares per tap,
// merges fail bits and decides early stop, end of sweep and error abort.
// Assumes: each cmp_req pulse gets exactly one later cmp_ack cycle.
module dws_ctrl
    import dws_pkg::*;
#(
    parameter int LANES   = 9,
    parameter int TAP_W   = 5,
    parameter int RETRIES = 3,
    parameter int VICTIMS = 8,
    parameter int VIC_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dir_tx,
    input  logic [LANES-1:0] en_in,
    input  logic             cmp_ack,
    input  logic [LANES-1:0] cmp_fail,
    input  logic             all_locked,
    input  logic             any_seek,
    output logic [TAP_W-1:0] tap,
    output logic [VIC_W-1:0] victim,
    output logic             is_tx,
    output logic [LANES-1:0] en_q,
    output logic [LANES-1:0] fail_acc,
    output logic             cmp_req,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             acc_init,
    output logic             arm,
    output logic             step,
    output logic             merge
);
    localparam int            ATT_W   = $clog2(RETRIES + 1);
    localparam logic [TAP_W-1:0] TAP_TOP = '1;

    sw_st_t           st;
    logic [ATT_W-1:0] att;
    logic             at_end;

    // Last tap of the sweep in the current direction.
    assign at_end = is_tx ? (tap == '0) : (tap == TAP_TOP);

    // Sequencer: arm, request, collect, step, decide, merge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= SW_IDLE;
            tap      <= '0;
            victim   <= '0;
            att      <= '0;
            is_tx    <= 1'b0;
            en_q     <= '0;
            fail_acc <= '0;
            err      <= 1'b0;
        end else begin
            case (st)
                SW_IDLE: if (start) begin
                    is_tx  <= dir_tx;
                    en_q   <= en_in;
                    victim <= '0;
                    err    <= 1'b0;
                    st     <= SW_ARM;
                end
                SW_ARM: begin
                    tap      <= is_tx ? TAP_TOP : '0;
                    att      <= '0;
                    fail_acc <= '0;
                    st       <= SW_REQ;
                end
                SW_REQ: st <= SW_WAIT;
                SW_WAIT: if (cmp_ack) begin
                    fail_acc <= fail_acc | cmp_fail;
                    if (att == ATT_W'(RETRIES - 1)) begin
                        st <= SW_STEP;
                    end else begin
                        att <= att + 1'b1;
                        st  <= SW_REQ;
                    end
                end
                SW_STEP: st <= SW_CHECK;
                SW_CHECK: begin
                    if (all_locked || at_end) begin
                        if (any_seek) begin
                            err <= 1'b1;
                            st  <= SW_DONE;
                        end else begin
                            st <= SW_MERGE;
                        end
                    end else begin
                        tap      <= is_tx ? tap - 1'b1 : tap + 1'b1;
                        att      <= '0;
                        fail_acc <= '0;
                        st       <= SW_REQ;
                    end
                end
                SW_MERGE: begin
                    if (victim == VIC_W'(VICTIMS - 1)) begin
                        st <= SW_DONE;
                    end else begin
                        victim <= victim + 1'b1;
                        st     <= SW_ARM;
                    end
                end
                default: st <= SW_IDLE;
            endcase
        end
    end

    // Strobes decoded from the sequencer state.
    always_comb begin
        cmp_req  = (st == SW_REQ);
        busy     = (st != SW_IDLE);
        done     = (st == SW_DONE);
        acc_init = (st == SW_IDLE) && start;
        arm      = (st == SW_ARM);
        step     = (st == SW_STEP);
        merge    = (st == SW_MERGE);
    end
endmodule

// File: rtl/dly_window_scan.sv
// Top: sequencer, one tracker per lane, and per-lane delay formation.
// Assumes: wl_off is static during a run; limits are valid at done.
module dly_window_scan #(
    parameter  int LANES   = 9,
    parameter  int TAP_W   = 5,
    parameter  int RETRIES = 3,
    parameter  int VICTIMS = 8,
    parameter  int MIN_WIN = 3,
    localparam int DLY_W   = TAP_W + 1,
    localparam int VIC_W   = (VICTIMS > 1) ? $clog2(VICTIMS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   dir_tx,
    input  logic [LANES-1:0]       lane_en,
    input  logic [LANES*TAP_W-1:0] wl_off,
    input  logic                   cmp_ack,
    input  logic [LANES-1:0]       cmp_fail,
    output logic                   cmp_req,
    output logic [VIC_W-1:0]       victim,
    output logic [LANES*DLY_W-1:0] lane_dly,
    output logic                   busy,
    output logic                   done,
    output logic                   err,
    output logic [LANES*TAP_W-1:0] low_lim,
    output logic [LANES*TAP_W-1:0] high_lim
);
    logic [TAP_W-1:0] tap;
    logic             is_tx, acc_init, arm, step, merge;
    logic [LANES-1:0] en_q, fail_acc, locked_v, seek_v;

    dws_ctrl #(
        .LANES(LANES), .TAP_W(TAP_W), .RETRIES(RETRIES),
        .VICTIMS(VICTIMS), .VIC_W(VIC_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_tx(dir_tx),
        .en_in(lane_en), .cmp_ack(cmp_ack), .cmp_fail(cmp_fail),
        .all_locked(&locked_v), .any_seek(|seek_v),
        .tap(tap), .victim(victim), .is_tx(is_tx), .en_q(en_q),
        .fail_acc(fail_acc), .cmp_req(cmp_req), .busy(busy), .done(done),
        .err(err), .acc_init(acc_init), .arm(arm), .step(step), .merge(merge)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        dws_lane #(.TAP_W(TAP_W), .MIN_WIN(MIN_WIN)) u_lane (
            .clk(clk), .rst_n(rst_n), .en(en_q[l]), .is_tx(is_tx), .tap(tap),
            .acc_init(acc_init), .arm(arm), .step(step), .fail(fail_acc[l]),
            .merge(merge), .locked(locked_v[l]), .seeking(seek_v[l]),
            .acc_lo(low_lim[l*TAP_W +: TAP_W]),
            .acc_hi(high_lim[l*TAP_W +: TAP_W])
        );

        // Transmit adds the lane's levelling offset; receive drives the tap.
        assign lane_dly[l*DLY_W +: DLY_W] = is_tx
            ? ({1'b0, tap} + {1'b0, wl_off[l*TAP_W +: TAP_W]})
            : {1'b0, tap};
    end
endmodule

// File: rtl/dws_checks.sv
// Protocol checks for the delay window scanner, bound to the top.
// Assumes: synchronous active-low reset.
module dws_checks #(
    parameter int LANES = 9,
    parameter int DLY_W = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic                   busy,
    input logic                   done,
    input logic                   cmp_req,
    input logic                   cmp_ack,
    input logic [LANES*DLY_W-1:0] lane_dly
);
    logic pending;

    // Tracks a compare that has been requested but not yet answered.
    always_ff @(posedge clk) begin
        if (!rst_n)       pending <= 1'b0;
        else if (cmp_req) pending <= 1'b1;
        else if (cmp_ack) pending <= 1'b0;
    end

    AST_REQ_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) cmp_req |=> !cmp_req); // R4
    AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n) pending |-> !cmp_req); // R4
    AST_DLY_HELD:     assert property (@(posedge clk) disable iff (!rst_n) pending |-> $stable(lane_dly)); // R3
    AST_DONE_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R2
    AST_START_BUSY:   assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R2
    AST_IDLE_NO_REQ:  assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !cmp_req); // R2
endmodule

bind dly_window_scan dws_checks #(.LANES(LANES), .DLY_W(DLY_W)) u_checks (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .cmp_req(cmp_req), .cmp_ack(cmp_ack), .lane_dly(lane_dly)
);

// File: tb/tb_dly_window_scan.sv
module tb_dly_window_scan;
    localparam int NL = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          dir_tx = 1'b0;
    logic [NL-1:0] lane_en = '0;
    logic [44:0]   wl_off = '0;
    logic          cmp_ack;
    logic [NL-1:0] cmp_fail;
    logic          cmp_req, busy, done, err;
    logic [2:0]    victim;
    logic [53:0]   lane_dly;
    logic [44:0]   low_lim, high_lim;

    int total = 0, bad = 0;
    int wlo[8][NL], whi[8][NL];
    int flo[NL], fhi[NL], off[NL], first_dly[NL];
    int reqcnt = 0;
    logic run_tx = 1'b0;
    logic g_on = 1'b0;
    int g_lane = 0, g_tap = 0, g_att = 0;

    dly_window_scan dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_tx(dir_tx),
        .lane_en(lane_en), .wl_off(wl_off), .cmp_ack(cmp_ack),
        .cmp_fail(cmp_fail), .cmp_req(cmp_req), .victim(victim),
        .lane_dly(lane_dly), .busy(busy), .done(done), .err(err),
        .low_lim(low_lim), .high_lim(high_lim)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lo_of(int l); return int'(low_lim[l*5 +: 5]); endfunction
    function automatic int hi_of(int l); return int'(high_lim[l*5 +: 5]); endfunction

    function automatic logic lane_fails(int l, int t, int v, int att);
        logic ok;
        ok = (t >= wlo[v][l] && t <= whi[v][l]) || (t >= flo[l] && t <= fhi[l]);
        if (g_on && v == 0 && l == g_lane && t == g_tap && att == g_att) ok = 1'b0;
        return !ok;
    endfunction

    // Compare engine model: answers each request after one or two cycles.
    initial begin
        int v;
        int d;
        logic [NL-1:0] f;
        cmp_ack = 1'b0;
        cmp_fail = '0;
        forever begin
            @(negedge clk);
            cmp_ack = 1'b0;
            if (rst_n && cmp_req) begin
                v = int'(victim);
                for (int l = 0; l < NL; l++) begin
                    d = int'(lane_dly[l*6 +: 6]);
                    if (reqcnt == 0) first_dly[l] = d;
                    f[l] = lane_fails(l, run_tx ? d - off[l] : d, v, reqcnt % 3);
                end
                reqcnt++;
                repeat (1 + reqcnt % 2) @(negedge clk);
                cmp_ack = 1'b1;
                cmp_fail = f;
            end
        end
    end

    task automatic clear_windows();
        for (int v = 0; v < 8; v++)
            for (int l = 0; l < NL; l++) begin wlo[v][l] = 99; whi[v][l] = -1; end
        for (int l = 0; l < NL; l++) begin flo[l] = 99; fhi[l] = -1; end
        g_on = 1'b0;
    endtask

    task automatic set_win(int l, int lo, int hi);
        for (int v = 0; v < 8; v++) begin wlo[v][l] = lo; whi[v][l] = hi; end
    endtask

    task automatic run_sweep(input logic tx, input logic [NL-1:0] mask);
        int guard;
        guard = 0;
        run_tx = tx;
        reqcnt = 0;
        @(negedge clk);
        dir_tx = tx; lane_en = mask; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && guard < 20000) begin @(negedge clk); guard++; end
        chk("R2 done pulse seen", int'(done), 1);
        chk("R2 busy with done", int'(busy), 1);
    endtask

    task automatic t_reset();
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 err", int'(err), 0);
        chk("R1 req", int'(cmp_req), 0);
        chk("R1 low lane0", lo_of(0), 0);
        chk("R1 high lane8", hi_of(8), 31);
    endtask

    task automatic t_no_window();
        clear_windows();
        run_sweep(1'b0, 9'h001);
        chk("R8 err", int'(err), 1);
        chk("R8 abort after one sweep", reqcnt, 96);
        @(negedge clk);
        chk("R2 idle after done", int'(busy), 0);
    endtask

    task automatic t_rx_basic();
        clear_windows();
        for (int l = 0; l < NL; l++) set_win(l, 4 + l, 14 + l);
        run_sweep(1'b0, 9'h1FF);
        chk("R2 err cleared", int'(err), 0);
        chk("R9 early stop count", reqcnt, 576);
        chk("R3 rx first delay", first_dly[5], 0);
        for (int l = 0; l < NL; l++) begin
            chk("R5 rx low", lo_of(l), 4 + l);
            chk("R5 rx high", hi_of(l), 14 + l);
        end
    endtask

    task automatic t_tx_basic();
        clear_windows();
        for (int l = 0; l < NL; l++) begin
            off[l] = 2 * l;
            wl_off[l*5 +: 5] = 5'(2 * l);
            set_win(l, 6, 17 + l);
        end
        run_sweep(1'b1, 9'h1FF);
        chk("R2 tx err", int'(err), 0);
        for (int l = 0; l < NL; l++) begin
            chk("R3 tx first delay", first_dly[l], 31 + 2 * l);
            chk("R5 tx low", lo_of(l), 6);
            chk("R5 tx high", hi_of(l), 17 + l);
        end
    endtask

    task automatic t_accumulate();
        clear_windows();
        for (int v = 0; v < 8; v++) begin
            wlo[v][0] = 5 + (v % 4); whi[v][0] = 25 - v;
        end
        set_win(1, 10, 20);
        run_sweep(1'b0, 9'h003);
        chk("R10 err", int'(err), 0);
        chk("R10 low is max", lo_of(0), 8);
        chk("R10 high is min", hi_of(0), 18);
        chk("R10 lane1 low", lo_of(1), 10);
        chk("R10 lane1 high", hi_of(1), 20);
        chk("R11 disabled low", lo_of(4), 0);
        chk("R11 disabled high", hi_of(4), 31);
        chk("R10 victim wrapped at last", int'(victim), 7);
    endtask

    task automatic t_sweep_end();
        clear_windows();
        set_win(0, 20, 31);
        run_sweep(1'b0, 9'h001);
        chk("R7 rx open low", lo_of(0), 20);
        chk("R7 rx open high", hi_of(0), 31);
        clear_windows();
        set_win(0, 0, 12);
        run_sweep(1'b1, 9'h001);
        chk("R7 tx open low", lo_of(0), 0);
        chk("R7 tx open high", hi_of(0), 12);
        chk("R7 no err", int'(err), 0);
    endtask

    task automatic t_false_pass();
        clear_windows();
        set_win(0, 10, 20); flo[0] = 2; fhi[0] = 3;
        set_win(1, 10, 13);
        run_sweep(1'b0, 9'h003);
        chk("R6 rx rearm low", lo_of(0), 10);
        chk("R6 rx rearm high", hi_of(0), 20);
        chk("R6 min width low", lo_of(1), 10);
        chk("R6 min width high", hi_of(1), 13);
        clear_windows();
        set_win(0, 5, 15); flo[0] = 27; fhi[0] = 28;
        run_sweep(1'b1, 9'h001);
        chk("R6 tx rearm low", lo_of(0), 5);
        chk("R6 tx rearm high", hi_of(0), 15);
        chk("R6 no err", int'(err), 0);
    endtask

    task automatic t_retry();
        clear_windows();
        set_win(0, 10, 20);
        g_on = 1'b1; g_lane = 0; g_tap = 15; g_att = 1;
        run_sweep(1'b0, 9'h001);
        chk("R4 single attempt fail low", lo_of(0), 10);
        chk("R4 single attempt fail high", hi_of(0), 14);
        g_on = 1'b0;
    endtask

    initial begin
        for (int l = 0; l < NL; l++) off[l] = 0;
        clear_windows();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_window();
        t_rx_basic();
        t_tx_basic();
        wl_off = '0;
        for (int l = 0; l < NL; l++) off[l] = 0;
        t_accumulate();
        t_sweep_end();
        t_false_pass();
        t_retry();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule